// File: doc/BRIEF.md
# Multi-Processor Lock Gate Bank

This block holds a bank of independent lock gates that several processors share over a simple register bus. Each gate is one byte. It holds zero while the gate is free. While a processor holds the gate, it holds that processor's owner code, which is the processor's index plus one. Zero is therefore never a valid owner.

A processor claims a gate by writing its own owner code to it. It then reads the gate back: if the read returns its own code, the claim won. A claim only takes effect on a free gate, so a processor that loses sees the winner's code instead. Only the current owner can release a gate, and it does so by writing zero.

Accesses arrive at most one per clock cycle on a request channel. Each access carries the index of the requesting processor. A read produces one response beat on the following cycle. The request channel has a ready signal, but it is held high at all times: the block accepts every valid beat and never applies back-pressure. The response channel has no ready input, so the consumer must take each response beat in the cycle it appears. A per-gate ownership vector shows which gates are currently held.

Top module: `sema_gate_bank`

## Requirements
- R1: After reset every gate reads zero, `gate_owned` is all zero and `rsp_valid` is low.
- R2: A write whose data equals the requesting processor's index plus one, sent to a free gate, stores that code. A later read of the gate returns that code.
- R3: A write of an owner code to a gate held by a different processor leaves the gate unchanged. A read then returns the holder's code.
- R4: A nonzero write whose data is not the requesting processor's index plus one is ignored, even when the gate is free.
- R5: A write of zero by the processor whose code is stored in a gate frees that gate.
- R6: A write of zero by any other processor leaves the gate unchanged.
- R7: When two claims to the same free gate arrive in consecutive cycles, the first one wins and the second leaves the gate unchanged.
- R8: A gate index at or above `NUM_GATES` addresses no gate. A write to it changes nothing. A read of it returns zero, with `rsp_valid` high.
- R9: A read accepted in cycle t raises `rsp_valid` in cycle t+1, with the gate value as updated by every write accepted before cycle t. Writes produce no response beat.
- R10: Bit g of `gate_owned` is high exactly when gate g holds a nonzero code. Gates change independently of one another.
- R11: `req_ready` is high in every cycle, including during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request beat present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_proc | input | PROC_W (2) | Index of the requesting processor |
| req_gate | input | IDX_W (8) | Gate index |
| req_wdata | input | 8 | Write data (owner code or zero) |
| rsp_valid | output | 1 | Read response beat |
| rsp_rdata | output | 8 | Gate value returned by a read |
| gate_owned | output | NUM_GATES (16) | Per-gate held flag |

## Verification
Claims are made against free gates, against gates held by another processor, and against gates already held by the claimer. Comparing these cases separates the free-only acceptance rule from a plain register write. Zero writes come from both the owner and a non-owner, which shows whether release is restricted to the owner. Writes of a foreign processor's code and of arbitrary values show whether the data is checked against the bus tag. Two claims in back-to-back cycles, and a read issued in the cycle right after a write, expose the ordering and response latency. Accesses to indices just past the bank and far past it test the range check.

// File: rtl/sema_pkg.sv
package sema_pkg;
  localparam int CODE_W = 8;
  typedef logic [CODE_W-1:0] owner_code_t;

  function automatic owner_code_t proc_to_code(input int unsigned idx);
    return owner_code_t'(idx + 1);
  endfunction
endpackage

// File: rtl/sema_req_decode.sv
module sema_req_decode #(
  parameter int NUM_GATES = 16,
  parameter int IDX_W     = 8
) (
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [IDX_W-1:0]     req_gate,
  output logic                 in_range,
  output logic [NUM_GATES-1:0] wr_sel
);
  assign in_range = (req_gate < IDX_W'(NUM_GATES));

  for (genvar g = 0; g < NUM_GATES; g++) begin : g_sel
    assign wr_sel[g] = req_valid && req_write && in_range && (req_gate == IDX_W'(g));
  end
endmodule

// File: rtl/sema_gate_cell.sv
module sema_gate_cell
  import sema_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel,
  input  owner_code_t wdata,
  input  owner_code_t writer_code,
  output owner_code_t value,
  output logic        owned
);
  owner_code_t cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
    end else if (sel) begin
      if (wdata == writer_code && cur_q == '0) begin
        cur_q <= writer_code;
      end else if (wdata == '0 && cur_q == writer_code) begin
        cur_q <= '0;
      end
    end
  end

  assign value = cur_q;
  assign owned = (cur_q != '0);
endmodule

// File: rtl/sema_rsp_reg.sv
module sema_rsp_reg
  import sema_pkg::*;
#(
  parameter int NUM_GATES = 16,
  parameter int IDX_W     = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_fire,
  input  logic        in_range,
  input  logic [IDX_W-1:0] req_gate,
  input  owner_code_t gate_val [NUM_GATES],
  output logic        rsp_valid,
  output owner_code_t rsp_rdata
);
  localparam int GATE_AW = (NUM_GATES > 1) ? $clog2(NUM_GATES) : 1;

  owner_code_t sel_val;

  always_comb begin
    sel_val = '0;
    if (in_range) sel_val = gate_val[req_gate[GATE_AW-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_fire;
      rsp_rdata <= rd_fire ? sel_val : '0;
    end
  end
endmodule

// File: rtl/sema_gate_bank.sv
module sema_gate_bank
  import sema_pkg::*;
#(
  parameter int NUM_GATES = 16,
  parameter int NUM_PROCS = 4,
  parameter int IDX_W     = 8,
  localparam int PROC_W   = (NUM_PROCS > 1) ? $clog2(NUM_PROCS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [PROC_W-1:0]    req_proc,
  input  logic [IDX_W-1:0]     req_gate,
  input  logic [7:0]           req_wdata,
  output logic                 rsp_valid,
  output logic [7:0]           rsp_rdata,
  output logic [NUM_GATES-1:0] gate_owned
);
  logic                 in_range;
  logic [NUM_GATES-1:0] wr_sel;
  owner_code_t          writer_code;
  owner_code_t          gate_val [NUM_GATES];

  assign req_ready   = 1'b1;
  assign writer_code = proc_to_code(int'(req_proc));

  sema_req_decode #(.NUM_GATES(NUM_GATES), .IDX_W(IDX_W)) u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_gate  (req_gate),
    .in_range  (in_range),
    .wr_sel    (wr_sel)
  );

  for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
    sema_gate_cell u_cell (
      .clk         (clk),
      .rst_n       (rst_n),
      .sel         (wr_sel[g]),
      .wdata       (req_wdata),
      .writer_code (writer_code),
      .value       (gate_val[g]),
      .owned       (gate_owned[g])
    );
  end

  sema_rsp_reg #(.NUM_GATES(NUM_GATES), .IDX_W(IDX_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_fire   (req_valid && !req_write),
    .in_range  (in_range),
    .req_gate  (req_gate),
    .gate_val  (gate_val),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );
endmodule

// File: rtl/sema_gate_bank_chk.sv
module sema_gate_bank_chk #(
  parameter int NUM_GATES = 16,
  parameter int NUM_PROCS = 4,
  parameter int IDX_W     = 8,
  parameter int PROC_W    = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 req_write,
  input logic [PROC_W-1:0]    req_proc,
  input logic [IDX_W-1:0]     req_gate,
  input logic [7:0]           req_wdata,
  input logic                 rsp_valid,
  input logic [7:0]           rsp_rdata,
  input logic [NUM_GATES-1:0] gate_owned
);
  localparam int GATE_AW = (NUM_GATES > 1) ? $clog2(NUM_GATES) : 1;

  logic       hit_gate;
  logic [7:0] own_code;
  assign hit_gate = req_gate < IDX_W'(NUM_GATES);
  assign own_code = 8'(req_proc) + 8'd1;

  // R2: own-code claim of a free gate leaves it held
  assert_claim_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && hit_gate && req_wdata == own_code
      && !gate_owned[req_gate[GATE_AW-1:0]]
    |=> gate_owned[$past(req_gate[GATE_AW-1:0])]);

  // R8: out-of-range read returns zero
  assert_range_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write && !hit_gate |=> rsp_valid && rsp_rdata == 8'd0);

  // R9: writes never produce a response
  assert_write_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write |=> !rsp_valid);

  // R10: ownership only changes after an accepted write, one gate at a time
  assert_owned_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
    gate_owned != $past(gate_owned)
    |-> $past(req_valid && req_write) && $countones(gate_owned ^ $past(gate_owned)) == 1);

  // R3: a response carries zero or a valid owner code
  assert_code_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_rdata <= 8'(NUM_PROCS));

  // R11: never back-pressures
  assert_ready_high_R11: assert property (@(posedge clk) disable iff (!rst_n) req_ready);
endmodule

bind sema_gate_bank sema_gate_bank_chk #(
  .NUM_GATES(NUM_GATES), .NUM_PROCS(NUM_PROCS), .IDX_W(IDX_W), .PROC_W(PROC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_proc(req_proc), .req_gate(req_gate),
  .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
  .gate_owned(gate_owned)
);

// File: tb/sema_gate_bank_bench.sv
`timescale 1ns/1ps
module sema_gate_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_proc = '0;
  logic [7:0]  req_gate = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [15:0] gate_owned;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sema_gate_bank u_sema_gate_bank (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_proc(req_proc), .req_gate(req_gate),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .gate_owned(gate_owned)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic wr, input logic [1:0] p, input logic [7:0] g, input logic [7:0] d);
    req_valid = 1'b1; req_write = wr; req_proc = p; req_gate = g; req_wdata = d;
  endtask

  task automatic access(input logic wr, input logic [1:0] p, input logic [7:0] g, input logic [7:0] d);
    @(negedge clk); drive(wr, p, g, d);
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic read_chk(input string tag, input logic [1:0] p, input logic [7:0] g, input logic [7:0] exp);
    access(1'b0, p, g, 8'd0);
    check({tag, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    check({tag, " rdata"}, 32'(rsp_rdata), 32'(exp));
  endtask

  task automatic t_reset;
    check("R1 gate_owned", 32'(gate_owned), 32'd0);
    check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    check("R11 ready", 32'(req_ready), 32'd1);
    read_chk("R1 gate0", 2'd0, 8'd0, 8'd0);
  endtask

  task automatic t_claim;
    access(1'b1, 2'd0, 8'd3, 8'd1);
    check("R9 no rsp on write", 32'(rsp_valid), 32'd0);
    check("R10 owned after claim", 32'(gate_owned), 32'h0008);
    read_chk("R2 claim read", 2'd0, 8'd3, 8'd1);
    access(1'b1, 2'd0, 8'd3, 8'd1);
    read_chk("R2 owner rewrite", 2'd0, 8'd3, 8'd1);
  endtask

  task automatic t_contend;
    access(1'b1, 2'd2, 8'd3, 8'd3);
    read_chk("R3 held by other", 2'd2, 8'd3, 8'd1);
  endtask

  task automatic t_bad_code;
    access(1'b1, 2'd1, 8'd5, 8'd7);
    read_chk("R4 arbitrary value", 2'd1, 8'd5, 8'd0);
    access(1'b1, 2'd1, 8'd5, 8'd1);
    read_chk("R4 foreign code", 2'd1, 8'd5, 8'd0);
    check("R4 owned", 32'(gate_owned), 32'h0008);
  endtask

  task automatic t_release;
    access(1'b1, 2'd1, 8'd3, 8'd0);
    read_chk("R6 non-owner zero", 2'd1, 8'd3, 8'd1);
    access(1'b1, 2'd0, 8'd3, 8'd0);
    check("R5 owned cleared", 32'(gate_owned), 32'd0);
    read_chk("R5 released", 2'd0, 8'd3, 8'd0);
  endtask

  task automatic t_back2back;
    @(negedge clk); drive(1'b1, 2'd1, 8'd7, 8'd2);
    @(negedge clk); drive(1'b1, 2'd3, 8'd7, 8'd4);
    @(negedge clk); drive(1'b0, 2'd3, 8'd7, 8'd0);
    @(negedge clk); req_valid = 1'b0;
    check("R7 first wins", 32'(rsp_rdata), 32'd2);
    check("R9 read right after write", 32'(rsp_valid), 32'd1);
    access(1'b1, 2'd1, 8'd7, 8'd0);
    check("R5 second release", 32'(gate_owned), 32'd0);
  endtask

  task automatic t_range;
    access(1'b1, 2'd0, 8'd16, 8'd1);
    access(1'b1, 2'd0, 8'd200, 8'd1);
    check("R8 write ignored", 32'(gate_owned), 32'd0);
    read_chk("R8 read 16", 2'd0, 8'd16, 8'd0);
    read_chk("R8 read 255", 2'd0, 8'd255, 8'd0);
    read_chk("R8 gate0 untouched", 2'd0, 8'd0, 8'd0);
  endtask

  task automatic t_independent;
    access(1'b1, 2'd0, 8'd0, 8'd1);
    access(1'b1, 2'd3, 8'd15, 8'd4);
    check("R10 two gates", 32'(gate_owned), 32'h8001);
    read_chk("R10 gate0", 2'd2, 8'd0, 8'd1);
    read_chk("R10 gate15", 2'd2, 8'd15, 8'd4);
    access(1'b1, 2'd0, 8'd0, 8'd0);
    check("R10 one released", 32'(gate_owned), 32'h8000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11 ready in reset", 32'(req_ready), 32'd1);
    rst_n = 1'b1;
    t_reset;
    t_claim;
    t_contend;
    t_bad_code;
    t_release;
    t_back2back;
    t_range;
    t_independent;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule